// File: doc/BRIEF.md
# Autonomous Ramp-Up / Ramp-Down Output Sequencer

This block switches a bank of eight device outputs on one at a time and then off one at a time, and repeats this without any further help from a processor. A host sets a step period and sets the run flag through a small write-only register port. After that the sequencer runs by itself on its own sequencer clock.

A 7-bit down-counter sets the step rate. Each time the counter expires it raises a one-cycle terminal-count pulse, and that pulse advances the sequence by one step. An internal step accumulator counts the steps taken in the current phase and returns to zero at each phase boundary. A direction output shows whether the bank is currently being powered up or powered down.

The host write port is assumed to be already timed to the sequencer clock. Clearing the run flag stops the block and returns it to the idle state. The synchronous active-low reset does the same and also clears the registers.

Top module: `led_ramp_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block becomes idle after that edge: `seq_out` is 0, `seq_dir_up` is 1 and `step_tc` is 0. The run flag is cleared, so after reset is released no step pulse appears until the host sets it.
- R2: A write (`cfg_we` high at a rising edge) behaves as follows. Address 0 loads the run flag from `cfg_wdata[0]`. Address 1 loads the step period P from `cfg_wdata[6:0]`.
- R3: While running, `step_tc` is a pulse lasting one cycle that repeats every P+1 cycles. With P = 0 it stays high on every cycle.
- R4: During power-up, each step sets the next higher output bit. After step k (counting from 1) the value is 2^k-1: 0x01, 0x03, ... 0xFF.
- R5: `seq_dir_up` is 1 while powering up. It falls to 0 on the step that sets bit 7, and it returns to 1 on the step that clears bit 0.
- R6: During power-down, outputs clear from bit 7 down to bit 0: 0x7F, 0x3F, ... 0x00. At every moment `seq_out` is a contiguous run of ones starting at bit 0.
- R7: The up/down cycle of 16 steps repeats indefinitely with no further host writes. Outputs change only on the cycle after a `step_tc` pulse or when the block stops.
- R8: Clearing the run flag brings the block to idle one cycle later (`seq_out` = 0, `seq_dir_up` = 1, `step_tc` = 0) and it stays there. Setting the flag again restarts the sequence from 0x01.
- R9: A new period written while running takes effect at the next counter reload. The interval already in progress finishes with the old period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_seq | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 run flag, 1 step period |
| cfg_wdata | input | 8 | Register write data |
| seq_out | output | 8 | Sequenced device enables, bit 0 first on |
| seq_dir_up | output | 1 | 1 while powering up, 0 while powering down |
| step_tc | output | 1 | Step timer terminal-count pulse |

## Verification
The assertions check on every cycle the properties that hold in any state:
- the outputs always form a contiguous run of ones starting at bit 0;
- the count of lit outputs agrees with the step accumulator in both phases;
- the direction flips only at a full or an empty bank;
- the outputs move only after a step pulse or a stop;
- the step pulse is single-cycle for non-zero periods.

Only the bench's scenarios can show the exact order of output values across two full cycles, the pulse spacing for several periods, the moment a period change takes effect, and the restart from 0x01 after a stop or a reset.

// File: rtl/led_seq_pkg.sv
// Package: shared constants and types for the output sequencer.
// Assumes: the default sizes are used as module parameter defaults only.
package led_seq_pkg;

    localparam int unsigned SEQ_OUTS   = 8;  // sequenced devices
    localparam int unsigned SEQ_PRE_W  = 7;  // step timer width
    localparam int unsigned SEQ_ACC_W  = 8;  // step accumulator width
    localparam int unsigned CFG_DATA_W = 8;  // host write data width

    // Sequencing phase; the value is also the direction output.
    typedef enum logic {
        PH_DOWN = 1'b0,
        PH_UP   = 1'b1
    } phase_e;

    // Register select codes on the host write port.
    typedef enum logic {
        CFG_RUN    = 1'b0,
        CFG_PERIOD = 1'b1
    } cfg_sel_e;

endpackage

// File: rtl/led_seq_cfg_regs.sv
// Module: host-written configuration registers (run flag, step period).
// Assumes: write strobe is synchronous to clk; DATA_W >= PRE_W.
module led_seq_cfg_regs
    import led_seq_pkg::*;
#(
    parameter int unsigned PRE_W      = SEQ_PRE_W,
    parameter int unsigned DATA_W     = CFG_DATA_W,
    parameter logic [PRE_W-1:0] PERIOD_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              run_en,
    output logic [PRE_W-1:0]  period
);

    logic             run_q;
    logic [PRE_W-1:0] period_q;

    // Run flag: loaded from data bit 0 on a write to the run register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (wr_en && (cfg_sel_e'(wr_sel) == CFG_RUN)) begin
            run_q <= wr_data[0];
        end
    end

    // Step period: loaded from the low data bits on a write to the period register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= PERIOD_RST;
        end else if (wr_en && (cfg_sel_e'(wr_sel) == CFG_PERIOD)) begin
            period_q <= wr_data[PRE_W-1:0];
        end
    end

    assign run_en = run_q;
    assign period = period_q;

endmodule

// File: rtl/led_seq_prescaler.sv
// Module: step timer. A down-counter that reloads from the period and
// raises a registered one-cycle tick on each expiry (every period+1 cycles).
// Assumes: the period is sampled only at reload, so a change applies to
// the next interval. The counter holds the period while stopped.
module led_seq_prescaler
    import led_seq_pkg::*;
#(
    parameter int unsigned W = SEQ_PRE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] reload,
    output logic         tick
);

    localparam logic [W-1:0] CNT_ZERO = '0;
    localparam logic [W-1:0] CNT_ONE  = W'(1);

    logic [W-1:0] cnt_q;
    logic         tick_q;

    // Countdown: preload while stopped, reload and pulse when expired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= CNT_ZERO;
            tick_q <= 1'b0;
        end else if (!run) begin
            cnt_q  <= reload;
            tick_q <= 1'b0;
        end else if (cnt_q == CNT_ZERO) begin
            cnt_q  <= reload;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q - CNT_ONE;
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;

endmodule

// File: rtl/led_seq_step_ctrl.sv
// Module: step engine. Keeps the per-phase step accumulator and the phase
// (direction), and sets or clears one output bit per step.
// Assumes: 2**ACC_W > N. A step is a single-cycle pulse from the step timer.
module led_seq_step_ctrl
    import led_seq_pkg::*;
#(
    parameter int unsigned N     = SEQ_OUTS,
    parameter int unsigned ACC_W = SEQ_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    output logic [N-1:0]     outs,
    output logic             dir_up,
    output logic [ACC_W-1:0] acc
);

    localparam logic [ACC_W-1:0] ACC_ZERO = '0;
    localparam logic [ACC_W-1:0] ACC_ONE  = ACC_W'(1);
    localparam logic [ACC_W-1:0] ACC_LAST = ACC_W'(N - 1);

    phase_e           phase_q;
    logic [ACC_W-1:0] acc_q;
    logic [N-1:0]     outs_q;
    logic             phase_end;

    assign phase_end = step && (acc_q == ACC_LAST);

    // Accumulator: cleared when idle and at each phase end, otherwise +1 per step.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            acc_q <= ACC_ZERO;
        end else if (phase_end) begin
            acc_q <= ACC_ZERO;
        end else if (step) begin
            acc_q <= acc_q + ACC_ONE;
        end
    end

    // Phase: starts powering up, flips when a phase completes its N steps.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= PH_UP;
        end else if (phase_end) begin
            phase_q <= (phase_q == PH_UP) ? PH_DOWN : PH_UP;
        end
    end

    // One register per output: set at its up-step, cleared at its down-step.
    for (genvar gi = 0; gi < N; gi++) begin : g_out
        localparam logic [ACC_W-1:0] UP_IDX = ACC_W'(gi);
        localparam logic [ACC_W-1:0] DN_IDX = ACC_W'(N - 1 - gi);

        logic set_bit;
        logic clr_bit;

        assign set_bit = step && (phase_q == PH_UP)   && (acc_q == UP_IDX);
        assign clr_bit = step && (phase_q == PH_DOWN) && (acc_q == DN_IDX);

        // Output bit gi: idle low, driven by its own set/clear step.
        always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
                outs_q[gi] <= 1'b0;
            end else if (set_bit) begin
                outs_q[gi] <= 1'b1;
            end else if (clr_bit) begin
                outs_q[gi] <= 1'b0;
            end
        end
    end

    assign outs   = outs_q;
    assign dir_up = (phase_q == PH_UP);
    assign acc    = acc_q;

endmodule

// File: rtl/led_ramp_sequencer.sv
// Module: top of the autonomous output sequencer. Joins the host
// registers, the step timer and the step engine.
// Assumes: host writes are already synchronous to clk_seq; reset is
// synchronous and active-low.
module led_ramp_sequencer
    import led_seq_pkg::*;
#(
    parameter int unsigned N_OUTS = SEQ_OUTS,
    parameter int unsigned PRE_W  = SEQ_PRE_W,
    parameter int unsigned ACC_W  = SEQ_ACC_W,
    parameter int unsigned DATA_W = CFG_DATA_W
) (
    input  logic              clk_seq,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [N_OUTS-1:0] seq_out,
    output logic              seq_dir_up,
    output logic              step_tc
);

    logic             run_en;
    logic [PRE_W-1:0] step_period;
    logic             step_tick;
    logic [ACC_W-1:0] step_acc;

    led_seq_cfg_regs #(
        .PRE_W  (PRE_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk_seq),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_addr),
        .wr_data (cfg_wdata),
        .run_en  (run_en),
        .period  (step_period)
    );

    led_seq_prescaler #(
        .W (PRE_W)
    ) u_timer (
        .clk    (clk_seq),
        .rst_n  (rst_n),
        .run    (run_en),
        .reload (step_period),
        .tick   (step_tick)
    );

    led_seq_step_ctrl #(
        .N     (N_OUTS),
        .ACC_W (ACC_W)
    ) u_steps (
        .clk    (clk_seq),
        .rst_n  (rst_n),
        .run    (run_en),
        .step   (step_tick),
        .outs   (seq_out),
        .dir_up (seq_dir_up),
        .acc    (step_acc)
    );

    assign step_tc = step_tick;

endmodule

// File: rtl/led_ramp_sequencer_chk.sv
// Module: property checker for the sequencer, bound into the top module.
// Assumes: it observes the top's internal run flag, period and accumulator.
module led_ramp_sequencer_chk #(
    parameter int unsigned N     = 8,
    parameter int unsigned PRE_W = 7,
    parameter int unsigned ACC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic [PRE_W-1:0] step_period,
    input logic [ACC_W-1:0] step_acc,
    input logic             step_tick,
    input logic [N-1:0]     leds,
    input logic             dir_up
);

    logic [N:0] leds_ext;
    assign leds_ext = {1'b0, leds};

    // R1: reset leaves the block idle with the run flag off
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (leds == '0 && dir_up && !step_tick && !run_en));

    // R3: non-zero period gives a single-cycle step pulse
    assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_tick && step_period != '0) |=> !step_tick);

    // R4: accumulator never reaches the phase length
    assert_acc_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(step_acc) < int'(N));

    // R4: lit count equals the accumulator while powering up
    assert_up_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dir_up |-> ($countones(leds) == int'(step_acc)));

    // R6: lit count equals N minus the accumulator while powering down
    assert_down_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_up |-> ($countones(leds) == int'(N) - int'(step_acc)));

    // R6: outputs always form a run of ones from bit 0
    assert_thermometer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((leds_ext + 1'b1) & leds_ext) == '0);

    // R5: direction flips only with a full or empty bank
    assert_dir_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_up != $past(dir_up)) |-> (leds == '0 || leds == '1));

    // R7: outputs move only after a step pulse or a stop
    assert_change_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (leds != $past(leds)) |-> ($past(step_tick) || !$past(run_en)));

    // R8: a stopped block is idle one cycle later
    assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (leds == '0 && dir_up && !step_tick));

endmodule

bind led_ramp_sequencer led_ramp_sequencer_chk #(
    .N     (N_OUTS),
    .PRE_W (PRE_W),
    .ACC_W (ACC_W)
) chk_i (
    .clk         (clk_seq),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .step_period (step_period),
    .step_acc    (step_acc),
    .step_tick   (step_tick),
    .leds        (seq_out),
    .dir_up      (seq_dir_up)
);

// File: tb/led_ramp_sequencer_tb_top.sv
// Bench: scoreboard for the sequencer. A driver task pushes the expected
// output and direction for each step; a monitor pops and compares them
// on the cycle after every step pulse.
module led_ramp_sequencer_tb_top;

    logic       clk_seq;
    logic       rst_n;
    logic       cfg_we;
    logic       cfg_addr;
    logic [7:0] cfg_wdata;
    logic [7:0] seq_out;
    logic       seq_dir_up;
    logic       step_tc;

    int n_checks = 0;
    int n_bad    = 0;

    typedef struct {
        logic [7:0] outs;
        logic       dir;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    bit   sb_live = 0;
    bit   tc_prev = 0;

    logic [7:0] m_outs;
    int         m_k;
    bit         m_up;
    int         m_total;

    led_ramp_sequencer dut_i (
        .clk_seq    (clk_seq),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .seq_out    (seq_out),
        .seq_dir_up (seq_dir_up),
        .step_tc    (step_tc)
    );

    initial clk_seq = 1'b0;
    always #4 clk_seq = ~clk_seq;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    // Called at a negedge: drive one write, captured at the next rising edge.
    task automatic cfg_write(input logic a, input logic [7:0] d);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk_seq);
        cfg_we    = 1'b0;
    endtask

    task automatic model_reset();
        m_outs  = 8'h00;
        m_k     = 0;
        m_up    = 1'b1;
        m_total = 0;
    endtask

    // Driver: push the expected state after each of the next n steps.
    task automatic push_steps(input int n);
        for (int i = 0; i < n; i++) begin
            exp_t  e;
            string tg;
            if (m_up) begin
                m_outs[m_k] = 1'b1;
                tg = "R4";
            end else begin
                m_outs[7 - m_k] = 1'b0;
                tg = "R6";
            end
            m_k++;
            if (m_k == 8) begin
                m_k  = 0;
                m_up = !m_up;
                tg   = "R5";
            end
            m_total++;
            if (m_total > 16) tg = "R7";
            e.outs = m_outs;
            e.dir  = m_up;
            e.tag  = tg;
            sb_q.push_back(e);
        end
    endtask

    task automatic wait_tc();
        while (!step_tc) @(negedge clk_seq);
    endtask

    // From a negedge with step_tc high (start cycles already elapsed), count to the next pulse.
    task automatic gap(input int start, output int n);
        n = start;
        do begin
            @(negedge clk_seq);
            n++;
        end while (!step_tc);
    endtask

    // Monitor: one cycle after each step pulse, compare against the queue head.
    always @(negedge clk_seq) begin
        if (tc_prev && sb_live) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R7", "step with empty scoreboard", 0, 1);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(seq_out == e.outs, e.tag, "seq_out", int'(seq_out), int'(e.outs));
                check(seq_dir_up == e.dir, e.tag, "seq_dir_up", int'(seq_dir_up), int'(e.dir));
            end
        end
        tc_prev = step_tc;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk_seq);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        int g;
        int tc_seen;
        rst_n     = 1'b0;
        cfg_we    = 1'b0;
        cfg_addr  = 1'b0;
        cfg_wdata = 8'h00;
        repeat (3) @(negedge clk_seq);

        // R1: reset state
        check(seq_out == 8'h00, "R1", "seq_out in reset", int'(seq_out), 0);
        check(seq_dir_up == 1'b1, "R1", "dir in reset", int'(seq_dir_up), 1);
        check(step_tc == 1'b0, "R1", "tc in reset", int'(step_tc), 0);
        rst_n = 1'b1;
        tc_seen = 0;
        repeat (20) begin
            @(negedge clk_seq);
            if (step_tc) tc_seen++;
        end
        check(tc_seen == 0, "R1", "pulses before run set", tc_seen, 0);

        // R2/R3/R4/R5/R6/R7: period 3, run continuously
        cfg_write(1'b1, 8'd3);
        model_reset();
        push_steps(40);
        sb_live = 1;
        cfg_write(1'b0, 8'h01);
        wait_tc();
        gap(0, g);
        check(g == 4, "R3", "pulse spacing P=3", g, 4);
        gap(0, g);
        check(g == 4, "R2", "period register P=3", g, 4);

        // R9: period change mid-run applies at next reload
        cfg_write(1'b1, 8'd0);
        gap(1, g);
        check(g == 4, "R9", "interval after write keeps old period", g, 4);
        gap(0, g);
        check(g == 1, "R9", "new period P=0 spacing", g, 1);
        gap(0, g);
        check(g == 1, "R3", "P=0 keeps pulse high", g, 1);
        while (sb_q.size() > 4) @(negedge clk_seq);

        // R8: stop
        sb_live = 0;
        cfg_write(1'b0, 8'h00);
        sb_q.delete();
        @(negedge clk_seq);
        check(seq_out == 8'h00, "R8", "seq_out after stop", int'(seq_out), 0);
        check(seq_dir_up == 1'b1, "R8", "dir after stop", int'(seq_dir_up), 1);
        check(step_tc == 1'b0, "R8", "tc after stop", int'(step_tc), 0);
        tc_seen = 0;
        repeat (20) begin
            @(negedge clk_seq);
            if (step_tc || seq_out != 8'h00) tc_seen++;
        end
        check(tc_seen == 0, "R8", "activity while stopped", tc_seen, 0);

        // R8: restart from 0x01 with P=2, one full cycle and more
        cfg_write(1'b1, 8'd2);
        model_reset();
        push_steps(20);
        sb_q[0].tag = "R8";
        sb_live = 1;
        cfg_write(1'b0, 8'h01);
        wait_tc();
        gap(0, g);
        check(g == 3, "R2", "period register P=2", g, 3);
        while (sb_q.size() > 0) @(negedge clk_seq);
        sb_live = 0;

        // R1: reset while running
        rst_n = 1'b0;
        repeat (2) @(negedge clk_seq);
        check(seq_out == 8'h00, "R1", "seq_out after mid-run reset", int'(seq_out), 0);
        check(seq_dir_up == 1'b1, "R1", "dir after mid-run reset", int'(seq_dir_up), 1);
        rst_n = 1'b1;
        tc_seen = 0;
        repeat (20) begin
            @(negedge clk_seq);
            if (step_tc) tc_seen++;
        end
        check(tc_seen == 0, "R1", "run flag cleared by reset", tc_seen, 0);

        finish_run();
    end

endmodule